// File: doc/BRIEF.md
# Peer Registration Table Controller

This block keeps the per-node view of a group of peers that share a memory region and signal each other through doorbell vectors. It takes a stream of control messages. Each message carries a signed position and a bit that says whether a notification handle comes with it. From the sign of the position, the handle bit and whether the addressed peer already holds vectors, the block decides what the message means. It then updates one of the following: a fixed-depth table of per-peer vector counts, the node's own identifier, the highest registered peer identifier, or a flag showing that the shared region is mapped.

A doorbell checker elsewhere reads the table through a combinational lookup port, together with the current highest peer identifier, to decide whether a ring is legal. When a vector is registered for the node's own identifier, a one-cycle pulse gives the new vector index so the receive path can attach an interrupt to it. Requests the table cannot hold are dropped and set a sticky error bit.

Top module: `peer_reg_ctrl`

## Requirements
- R1: A message without a handle, with a non-negative position whose table count is zero (or whose position is at or beyond the table depth), sets the own identifier to that position on the next clock and changes no table count.
- R2: A message without a handle, addressed to an in-range peer whose count is non-zero, clears that peer's count to zero on the next clock; the own and maximum identifiers are unchanged.
- R3: A message with a handle and position all ones (-1) sets the mapped flag and forces the maximum peer identifier to 0 on the next clock.
- R4: A message with a handle and an in-range non-negative position whose count is below the limit increments that peer's count by one.
- R5: On a registration, the maximum peer identifier takes the position if the position is greater than it; otherwise it keeps its value.
- R6: After reset the own identifier is all ones, the maximum identifier is 0, every count is 0, and the mapped flag, error bit and bind pulse are low.
- R7: No count ever exceeds the parameter VEC_LIMIT (default 1); a registration to a peer already at the limit leaves its count unchanged.
- R8: A registration whose position equals the own identifier raises bind_valid for exactly one cycle, with bind_vector equal to the count before the increment; any other registration leaves bind_valid low.
- R9: A message with a handle that targets a full peer, a position at or beyond the table depth, or a negative position other than -1 changes no state except the error bit, which is set and then stays set until reset.
- R10: A message without a handle and with a negative position has no effect.
- R11: msg_ready is high from the first clock after reset. A message is taken in each cycle in which msg_valid and msg_ready are both high, and no state changes in a cycle without msg_valid.
- R12: lookup_count shows, in the same cycle, the stored count of the peer chosen by lookup_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Control message present |
| msg_ready | output | 1 | Controller can take a message |
| msg_pos | input | POS_W | Signed position carried by the message |
| msg_has_handle | input | 1 | A notification handle comes with the message |
| lookup_id | input | IDX_W | Peer index queried by the doorbell checker |
| lookup_count | output | CNT_W | Registered vector count of the queried peer |
| max_peer | output | POS_W | Highest registered peer identifier |
| own_id | output | POS_W | This node's identifier, all ones until assigned |
| shm_mapped | output | 1 | Shared region has been mapped |
| bind_valid | output | 1 | One-cycle pulse: own vector registered |
| bind_vector | output | CNT_W | Index of the vector just registered for this node |
| err_sticky | output | 1 | A registration was rejected since reset |

## Verification
The decoding is exercised with messages that differ in only one of its three inputs. The same position arrives with and without a handle, which separates registration from identity assignment. A peer is sent a handle-less message both before and after it holds vectors, which separates identity assignment from departure. Position -1 arrives with a handle (mapping) and a negative value arrives without one (ignored). Registrations go to the node's own position and to other positions, which shows that the bind pulse follows the own identifier. A peer is filled up to its limit, and an out-of-range target and a negative target are sent after it, to show that rejection changes only the error bit. The maximum identifier is pushed up and then cleared by a mapping message.

// File: rtl/peer_reg_pkg.sv
package peer_reg_pkg;

  typedef enum logic [2:0] {
    K_IDLE,
    K_OWN,
    K_DEPART,
    K_SHM,
    K_REG,
    K_REJECT
  } msg_kind_e;

  // Meaning of an accepted message from its sign, handle bit and table state.
  function automatic msg_kind_e classify(input logic fire, input logic has_h,
                                         input logic neg, input logic is_m1,
                                         input logic in_range, input logic seen,
                                         input logic full);
    msg_kind_e k;
    if (!fire)                          k = K_IDLE;
    else if (!has_h) begin
      if (neg)                          k = K_IDLE;
      else if (in_range && seen)        k = K_DEPART;
      else                              k = K_OWN;
    end
    else if (is_m1)                     k = K_SHM;
    else if (neg || !in_range || full)  k = K_REJECT;
    else                                k = K_REG;
    return k;
  endfunction

endpackage

// File: rtl/peer_count_table.sv
module peer_count_table #(
  parameter int NUM_PEERS = 16,
  parameter int VEC_LIMIT = 1,
  localparam int IDX_W = $clog2(NUM_PEERS),
  localparam int CNT_W = $clog2(VEC_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic [IDX_W-1:0] lookup_idx,
  output logic [CNT_W-1:0] sel_count,
  output logic [CNT_W-1:0] lookup_count
);

  logic [CNT_W-1:0] cnt_q [NUM_PEERS];

  for (genvar i = 0; i < NUM_PEERS; i++) begin : g_entry
    logic hit;
    assign hit = (sel_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q[i] <= '0;
      else if (clr_en && hit)   cnt_q[i] <= '0;
      else if (inc_en && hit)   cnt_q[i] <= cnt_q[i] + 1'b1;
    end

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !clr_en && hit) |=> cnt_q[i] == $past(cnt_q[i]) + 1'b1);

    a_r2_depart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && hit) |=> cnt_q[i] == '0);

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[i] <= CNT_W'(VEC_LIMIT));
  end

  assign sel_count    = cnt_q[sel_idx];
  assign lookup_count = cnt_q[lookup_idx];

endmodule

// File: rtl/peer_msg_decode.sv
module peer_msg_decode
  import peer_reg_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int VEC_LIMIT = 1,
  parameter int POS_W     = 16,
  localparam int CNT_W = $clog2(VEC_LIMIT + 1)
) (
  input  logic             fire,
  input  logic             has_handle,
  input  logic [POS_W-1:0] pos,
  input  logic [CNT_W-1:0] sel_count,
  output msg_kind_e        kind
);

  logic neg, is_m1, in_range, seen, full;

  assign neg      = pos[POS_W-1];
  assign is_m1    = &pos;
  assign in_range = !neg && (pos < POS_W'(NUM_PEERS));
  assign seen     = (sel_count != '0);
  assign full     = (sel_count == CNT_W'(VEC_LIMIT));

  assign kind = classify(fire, has_handle, neg, is_m1, in_range, seen, full);

endmodule

// File: rtl/peer_reg_ctrl.sv
module peer_reg_ctrl
  import peer_reg_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int VEC_LIMIT = 1,
  parameter int POS_W     = 16,
  localparam int IDX_W = $clog2(NUM_PEERS),
  localparam int CNT_W = $clog2(VEC_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [POS_W-1:0] msg_pos,
  input  logic             msg_has_handle,
  input  logic [IDX_W-1:0] lookup_id,
  output logic [CNT_W-1:0] lookup_count,
  output logic [POS_W-1:0] max_peer,
  output logic [POS_W-1:0] own_id,
  output logic             shm_mapped,
  output logic             bind_valid,
  output logic [CNT_W-1:0] bind_vector,
  output logic             err_sticky
);

  function automatic logic raises_max(input logic [POS_W-1:0] p,
                                      input logic [POS_W-1:0] m);
    return p > m;
  endfunction

  logic             rdy_q, fire;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] sel_count;
  msg_kind_e        kind;
  logic             ev_reg, ev_depart, ev_own, ev_shm, ev_reject;

  logic [POS_W-1:0] own_q, max_q;
  logic             shm_q, err_q, bind_q;
  logic [CNT_W-1:0] bvec_q;

  assign fire = msg_valid && rdy_q;
  assign idx  = msg_pos[IDX_W-1:0];

  peer_msg_decode #(
    .NUM_PEERS(NUM_PEERS), .VEC_LIMIT(VEC_LIMIT), .POS_W(POS_W)
  ) u_decode (
    .fire(fire), .has_handle(msg_has_handle), .pos(msg_pos),
    .sel_count(sel_count), .kind(kind)
  );

  assign ev_reg    = (kind == K_REG);
  assign ev_depart = (kind == K_DEPART);
  assign ev_own    = (kind == K_OWN);
  assign ev_shm    = (kind == K_SHM);
  assign ev_reject = (kind == K_REJECT);

  peer_count_table #(
    .NUM_PEERS(NUM_PEERS), .VEC_LIMIT(VEC_LIMIT)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .inc_en(ev_reg), .clr_en(ev_depart),
    .sel_idx(idx), .lookup_idx(lookup_id),
    .sel_count(sel_count), .lookup_count(lookup_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      own_q  <= '1;
      max_q  <= '0;
      shm_q  <= 1'b0;
      err_q  <= 1'b0;
      bind_q <= 1'b0;
      bvec_q <= '0;
    end else begin
      rdy_q  <= 1'b1;
      bind_q <= 1'b0;
      if (ev_own) own_q <= msg_pos;
      if (ev_shm) begin
        shm_q <= 1'b1;
        max_q <= '0;
      end
      if (ev_reg) begin
        if (raises_max(msg_pos, max_q)) max_q <= msg_pos;
        bind_q <= (msg_pos == own_q);
        bvec_q <= sel_count;
      end
      if (ev_reject) err_q <= 1'b1;
    end
  end

  assign msg_ready   = rdy_q;
  assign own_id      = own_q;
  assign max_peer    = max_q;
  assign shm_mapped  = shm_q;
  assign err_sticky  = err_q;
  assign bind_valid  = bind_q;
  assign bind_vector = bvec_q;

  a_r3_map_clears_max: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shm |=> (shm_q && max_q == '0));

  a_r5_max_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_shm |=> max_q >= $past(max_q));

  a_r8_bind_from_reg: assert property (@(posedge clk) disable iff (!rst_n)
    bind_q |-> ($past(ev_reg) && bvec_q < CNT_W'(VEC_LIMIT)));

  a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  a_r1_own_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_own |=> own_q == $past(own_q));

  a_r11_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> ($stable(own_q) && $stable(max_q) && $stable(shm_q) && !bind_q));

endmodule

// File: tb/peer_reg_ctrl_test.sv
module peer_reg_ctrl_test;

  localparam int NP = 8;
  localparam int VL = 3;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          msg_valid = 1'b0;
  logic          msg_ready;
  logic [PW-1:0] msg_pos = '0;
  logic          msg_has_handle = 1'b0;
  logic [2:0]    lookup_id = '0;
  logic [1:0]    lookup_count;
  logic [PW-1:0] max_peer, own_id;
  logic          shm_mapped, bind_valid, err_sticky;
  logic [1:0]    bind_vector;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  peer_reg_ctrl #(.NUM_PEERS(NP), .VEC_LIMIT(VL), .POS_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_pos(msg_pos), .msg_has_handle(msg_has_handle),
    .lookup_id(lookup_id), .lookup_count(lookup_count),
    .max_peer(max_peer), .own_id(own_id), .shm_mapped(shm_mapped),
    .bind_valid(bind_valid), .bind_vector(bind_vector), .err_sticky(err_sticky)
  );

  typedef struct packed {
    logic        hh;
    logic [15:0] pos;
    logic [2:0]  look;
    logic [1:0]  cnt;
    logic [15:0] maxp;
    logic [15:0] own;
    logic        shm;
    logic        bnd;
    logic [1:0]  bvec;
  } row_t;

  localparam row_t ROWS [9] = '{
    '{1'b0, 16'd5,      3'd5, 2'd0, 16'd0, 16'd5, 1'b0, 1'b0, 2'd0},
    '{1'b1, 16'hFFFF,   3'd5, 2'd0, 16'd0, 16'd5, 1'b1, 1'b0, 2'd0},
    '{1'b1, 16'd2,      3'd2, 2'd1, 16'd2, 16'd5, 1'b1, 1'b0, 2'd0},
    '{1'b1, 16'd5,      3'd5, 2'd1, 16'd5, 16'd5, 1'b1, 1'b1, 2'd0},
    '{1'b1, 16'd5,      3'd5, 2'd2, 16'd5, 16'd5, 1'b1, 1'b1, 2'd1},
    '{1'b1, 16'd3,      3'd3, 2'd1, 16'd5, 16'd5, 1'b1, 1'b0, 2'd0},
    '{1'b1, 16'd2,      3'd2, 2'd2, 16'd5, 16'd5, 1'b1, 1'b0, 2'd0},
    '{1'b0, 16'd2,      3'd2, 2'd0, 16'd5, 16'd5, 1'b1, 1'b0, 2'd0},
    '{1'b1, 16'd5,      3'd5, 2'd3, 16'd5, 16'd5, 1'b1, 1'b1, 2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One message in one cycle; returns at the negedge after the accepting edge.
  task automatic send(input logic hh, input logic [PW-1:0] pos, input logic [2:0] look);
    @(negedge clk);
    msg_valid = 1'b1; msg_has_handle = hh; msg_pos = pos; lookup_id = look;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state, R11 ready
    chk("R6 own", own_id, 32'hFFFF);
    chk("R6 max", max_peer, 0);
    chk("R6 shm", shm_mapped, 0);
    chk("R6 err", err_sticky, 0);
    chk("R6 bind", bind_valid, 0);
    lookup_id = 3'd4; #1;
    chk("R6 count", lookup_count, 0);
    chk("R11 ready", msg_ready, 1);

    // Table walk: R1 R2 R3 R4 R5 R8 R12
    for (int i = 0; i < 9; i++) begin
      send(ROWS[i].hh, ROWS[i].pos, ROWS[i].look);
      chk("R4/R2/R12 count", lookup_count, ROWS[i].cnt);
      chk("R5 max", max_peer, ROWS[i].maxp);
      chk("R1 own", own_id, ROWS[i].own);
      chk("R3 shm", shm_mapped, ROWS[i].shm);
      chk("R8 bind", bind_valid, ROWS[i].bnd);
      if (ROWS[i].bnd) chk("R8 vector", bind_vector, ROWS[i].bvec);
      chk("R9 err clear", err_sticky, 0);
    end

    // R10 negative without handle: nothing changes
    send(1'b0, 16'hFFFD, 3'd5);
    chk("R10 own", own_id, 5);
    chk("R10 count", lookup_count, 3);
    chk("R10 err", err_sticky, 0);

    // R1 unseen peer 7 becomes own id, its count stays 0
    send(1'b0, 16'd7, 3'd7);
    chk("R1 own7", own_id, 7);
    chk("R1 no table change", lookup_count, 0);

    // R9 negative other than -1 with handle
    send(1'b1, 16'hFFFE, 3'd5);
    chk("R9 err neg", err_sticky, 1);
    chk("R9 max kept", max_peer, 5);
    chk("R9 count kept", lookup_count, 3);

    // R9 beyond table depth (index bits alias peer 1)
    send(1'b1, 16'd9, 3'd1);
    chk("R9 depth count", lookup_count, 0);
    chk("R9 depth max", max_peer, 5);

    // R7 full peer
    send(1'b1, 16'd5, 3'd5);
    chk("R7 full count", lookup_count, 3);
    chk("R7 no bind", bind_valid, 0);

    // R8 own registration after error, R9 sticky, R5 max raise
    send(1'b1, 16'd7, 3'd7);
    chk("R4 count7", lookup_count, 1);
    chk("R8 bind7", bind_valid, 1);
    chk("R8 vec7", bind_vector, 0);
    chk("R5 max7", max_peer, 7);
    chk("R9 sticky", err_sticky, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", bind_valid, 0);

    // R11 no valid: no change
    msg_has_handle = 1'b1; msg_pos = 16'd6; lookup_id = 3'd6;
    @(negedge clk); @(negedge clk);
    chk("R11 idle count", lookup_count, 0);
    chk("R11 idle max", max_peer, 7);

    // R3 mapping clears max again
    send(1'b1, 16'hFFFF, 3'd7);
    chk("R3 max cleared", max_peer, 0);
    chk("R3 count kept", lookup_count, 1);

    // R6 reset again
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    lookup_id = 3'd5; #1;
    chk("R6 count after reset", lookup_count, 0);
    chk("R6 own after reset", own_id, 32'hFFFF);
    chk("R6 err after reset", err_sticky, 0);
    chk("R6 shm after reset", shm_mapped, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule